// File: doc/BRIEF.md
# Power-Up Interface Mode Detector

This block makes a single decision per powered session: after the power-on reset is released it lets the clock-pin bias network settle, then looks at two pins, each already decoded into one of three levels. From what it sees, it picks one of two interface modes for the command logic that follows. If both pins are left floating, the chip runs in pushbutton mode. Any driven level on either pin selects pulse mode.

The decision is taken on one clock cycle at the end of a settle window of `SETTLE_CYCLES` clocks. It is held until reset is asserted again. Pin activity after the decision has no effect.

The block also drives the enable for the pin bias resistors. The enable stays on while the block waits and whenever pushbutton mode is chosen. It drops when pulse mode is chosen, so that the pins then act as ordinary CMOS inputs. A one-cycle strobe marks the moment the decision lands, and a valid flag stays high from then on.

Top module: `pwrup_mode_detect`

## Requirements
- R1: While reset is low at a clock edge, and after that edge, the outputs read: mode pulse (`mode_pushbutton`=0), `mode_valid`=0, `sample_done`=0, `bias_en`=1.
- R2: Each pin level uses a 2-bit code: 2'b00 is low, 2'b01 is high and 2'b10 is floating. The code 2'b11 counts as a driven level.
- R3: Pushbutton mode (`mode_pushbutton`=1) is chosen only when both pins carry the floating code at the sampling edge.
- R4: If one pin is floating and the other carries any other code, pulse mode (`mode_pushbutton`=0) is chosen.
- R5: The pins are sampled on the `SETTLE_CYCLES`-th rising edge after the first edge that sees reset high. `mode_valid` and `sample_done` go high right after that edge, and `mode_valid` stays low before it.
- R6: `sample_done` stays high for exactly one clock cycle per decision.
- R7: Once `mode_valid` is high, pin changes do not alter `mode_pushbutton` or `bias_en` until the next reset.
- R8: `bias_en` stays high until the decision. After the decision it equals `mode_pushbutton`.
- R9: Asserting reset at any time clears the decision and restarts the full settle window.
- R10: Only the pin codes present at the sampling edge matter. Earlier codes inside the settle window have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| pin_a_lvl | input | 2 | Decoded level of the first clock pin |
| pin_b_lvl | input | 2 | Decoded level of the second clock pin |
| mode_pushbutton | output | 1 | 1 = pushbutton mode, 0 = pulse mode |
| mode_valid | output | 1 | High once the decision is latched |
| sample_done | output | 1 | One-cycle strobe after the sampling edge |
| bias_en | output | 1 | Keeps the pin bias resistors connected |

## Verification
The decision is driven with several pin pairs: both floating, both driven, one floating beside a low, a high or the illegal code, and the illegal code on both pins. Together these separate the single pushbutton case from every form of pulse mode. Two cases switch the pins on the cycle just before the sampling edge, in both directions. They show that only the sampling edge counts and that an early sample or a sticky flag would be caught. Reset asserted in the middle of the settle window, and again after the decision, confirms that the window restarts and that the latch clears. Pin flips after the decision confirm that the held mode and the bias enable stay put.

// File: rtl/pmd_pkg.sv
// Package: shared encodings for the power-up mode detector.
// Assumes the upstream pad sensing delivers one 2-bit code per pin.
package pmd_pkg;

    // Decoded level of one clock pin
    typedef enum logic [1:0] {
        LVL_LOW   = 2'b00,
        LVL_HIGH  = 2'b01,
        LVL_FLOAT = 2'b10,
        LVL_BAD   = 2'b11
    } pin_lvl_e;

    // Sequencing state of the settle timer
    typedef enum logic {
        ST_SETTLE = 1'b0,
        ST_LOCKED = 1'b1
    } det_state_e;

endpackage

// File: rtl/pmd_settle_timer.sv
// Module: pmd_settle_timer
// Counts SETTLE_CYCLES clocks after reset release and raises a single
// sample request on the last one. It then parks until the next reset.
// Assumes SETTLE_CYCLES >= 1 and a synchronous active-low reset.
module pmd_settle_timer
    import pmd_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic sample_now
);

    localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE_CYCLES - 1);

    det_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    // Request a sample on the final cycle of the settle window
    always_comb begin
        sample_now = (state_q == ST_SETTLE) && (cnt_q == LAST_CNT);
    end

    // Advance the settle counter and lock after the sampling cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE;
            cnt_q   <= '0;
        end else if (state_q == ST_SETTLE) begin
            if (cnt_q == LAST_CNT) begin
                state_q <= ST_LOCKED;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);  // R5

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED) |=> (state_q == ST_LOCKED) && !sample_now);  // R7

endmodule

// File: rtl/pmd_level_classify.sv
// Module: pmd_level_classify
// Flags whether one pin's decoded level is the floating code. Every other
// code, including the illegal one, counts as driven.
// Assumes the code is already synchronous to clk.
module pmd_level_classify
    import pmd_pkg::*;
(
    input  logic [1:0] lvl,
    output logic       is_float
);

    // Detect the floating code; low, high and illegal all count as driven
    always_comb begin
        is_float = (pin_lvl_e'(lvl) == LVL_FLOAT);
    end

endmodule

// File: rtl/pmd_decision_latch.sv
// Module: pmd_decision_latch
// Captures the mode on the sample request, pulses done for one cycle and
// holds the result until reset. It also derives the bias enable.
// Assumes sample_now fires at most once per reset session.
module pmd_decision_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_now,
    input  logic all_float,
    output logic mode_pb,
    output logic valid,
    output logic done,
    output logic bias_en
);

    logic mode_q;
    logic valid_q;
    logic done_q;

    // Latch the decision once and generate the done strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= sample_now && !valid_q;
            if (sample_now && !valid_q) begin
                mode_q  <= all_float;
                valid_q <= 1'b1;
            end
        end
    end

    // Keep the bias network on until a driven pin has been seen
    always_comb begin
        bias_en = !valid_q || mode_q;
    end

    assign mode_pb = mode_q;
    assign valid   = valid_q;
    assign done    = done_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);  // R6

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> valid_q && $stable(mode_q));  // R7

    AST_PB_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> !mode_q);  // R1

    AST_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> done_q);  // R5

endmodule

// File: rtl/pwrup_mode_detect.sv
// Module: pwrup_mode_detect (top)
// Chooses pushbutton or pulse interface mode once after power-on reset from
// two three-level clock pins, and drives the pin bias-resistor enable.
// Assumes the pin codes are already synchronized and that rst_n is the supply reset.
module pwrup_mode_detect
    import pmd_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16,
    parameter int NUM_PINS      = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pin_a_lvl,
    input  logic [1:0] pin_b_lvl,
    output logic       mode_pushbutton,
    output logic       mode_valid,
    output logic       sample_done,
    output logic       bias_en
);

    logic [NUM_PINS-1:0][1:0] pin_lvl;
    logic [NUM_PINS-1:0]      pin_float;
    logic                     all_float;
    logic                     sample_now;

    assign pin_lvl[0] = pin_a_lvl;
    assign pin_lvl[1] = pin_b_lvl;

    // One classifier per pin
    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
        pmd_level_classify u_cls (
            .lvl      (pin_lvl[gi]),
            .is_float (pin_float[gi])
        );
    end

    // Pushbutton mode requires every pin to float
    always_comb begin
        all_float = &pin_float;
    end

    pmd_settle_timer #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_now (sample_now)
    );

    pmd_decision_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_now (sample_now),
        .all_float  (all_float),
        .mode_pb    (mode_pushbutton),
        .valid      (mode_valid),
        .done       (sample_done),
        .bias_en    (bias_en)
    );

    AST_BIAS_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid |-> (bias_en == mode_pushbutton));  // R8

    AST_BIAS_BEFORE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_valid |-> bias_en);  // R8

    AST_PB_ONLY_ALL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        sample_now && ((pin_a_lvl != 2'b10) || (pin_b_lvl != 2'b10)) |=> !mode_pushbutton);  // R4

endmodule

// File: tb/pwrup_mode_detect_test.sv
module pwrup_mode_detect_test;

    localparam int SETTLE = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pin_a = 2'b10;
    logic [1:0] pin_b = 2'b10;
    logic       mode_pb, valid, done, bias;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    pwrup_mode_detect #(.SETTLE_CYCLES(SETTLE)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .pin_a_lvl       (pin_a),
        .pin_b_lvl       (pin_b),
        .mode_pushbutton (mode_pb),
        .mode_valid      (valid),
        .sample_done     (done),
        .bias_en         (bias)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Reset, then release on a falling edge
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        edges(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        edges(1);
        chk("R1", "mode", mode_pb, 1'b0);
        chk("R1", "valid", valid, 1'b0);
        chk("R1", "done", done, 1'b0);
        chk("R1", "bias", bias, 1'b1);
    endtask

    // Full decision for one pin pair, then flip pins and confirm hold
    task automatic t_decide(input logic [1:0] a, input logic [1:0] b,
                            input logic exp_pb, input string req);
        pin_a = a;
        pin_b = b;
        do_reset();
        edges(SETTLE - 1);
        chk("R5", "valid before window end", valid, 1'b0);
        chk("R8", "bias during settle", bias, 1'b1);
        chk("R1", "mode before decision", mode_pb, 1'b0);
        edges(1);
        chk("R5", "valid at sample", valid, 1'b1);
        chk("R5", "done at sample", done, 1'b1);
        chk(req, "mode", mode_pb, exp_pb);
        chk("R8", "bias after decision", bias, exp_pb);
        pin_a = exp_pb ? 2'b00 : 2'b10;
        pin_b = exp_pb ? 2'b01 : 2'b10;
        edges(1);
        chk("R6", "done drops", done, 1'b0);
        chk("R7", "mode held", mode_pb, exp_pb);
        edges(5);
        chk("R7", "mode held later", mode_pb, exp_pb);
        chk("R7", "bias held later", bias, exp_pb);
        chk("R6", "no second done", done, 1'b0);
    endtask

    // Change pins on the cycle before the sampling edge
    task automatic t_late_change(input logic [1:0] early, input logic [1:0] late,
                                 input logic exp_pb);
        pin_a = early;
        pin_b = early;
        do_reset();
        edges(SETTLE - 1);
        pin_a = late;
        pin_b = late;
        edges(1);
        chk("R10", "late pins decide", mode_pb, exp_pb);
        chk("R10", "valid", valid, 1'b1);
    endtask

    // Reset in the middle of the window restarts it; reset after lock clears
    task automatic t_reset_restart();
        pin_a = 2'b10;
        pin_b = 2'b10;
        do_reset();
        edges(SETTLE / 2);
        rst_n = 1'b0;
        edges(1);
        chk("R9", "valid cleared", valid, 1'b0);
        edges(1);
        rst_n = 1'b1;
        edges(SETTLE - 1);
        chk("R9", "window restarted", valid, 1'b0);
        edges(1);
        chk("R9", "decision after restart", valid, 1'b1);
        chk("R3", "pushbutton after restart", mode_pb, 1'b1);
        rst_n = 1'b0;
        edges(1);
        chk("R9", "mode cleared", mode_pb, 1'b0);
        chk("R9", "valid cleared after lock", valid, 1'b0);
        chk("R9", "bias restored", bias, 1'b1);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset_state();
        t_decide(2'b10, 2'b10, 1'b1, "R3");
        t_decide(2'b00, 2'b01, 1'b0, "R3");
        t_decide(2'b10, 2'b00, 1'b0, "R4");
        t_decide(2'b01, 2'b10, 1'b0, "R4");
        t_decide(2'b11, 2'b10, 1'b0, "R2");
        t_decide(2'b11, 2'b11, 1'b0, "R2");
        t_decide(2'b01, 2'b01, 1'b0, "R2");
        t_late_change(2'b10, 2'b00, 1'b0);
        t_late_change(2'b01, 2'b10, 1'b1);
        t_reset_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule